// File: doc/BRIEF.md
# Dual-Bank Bulk Receive Buffer

This block sits between the serial interface engine of a USB bulk-OUT endpoint and the CPU. The engine delivers each received packet one byte at a time, and a separate strobe marks the end of the packet. The block writes these bytes into one of two packet banks. The engine side and the CPU side each step through the banks in alternation, so one packet can be drained while the next one arrives. The CPU sees two read-only registers. The first is a data window that hands out the next unread bytes of the selected bank. The second is a byte-count register that always shows how many bytes of the selected bank are still unread.

Each bank has its own state machine with three states. FREE means empty. FILL means a packet is being written. LOADED means a complete packet is waiting for the CPU. The transitions are:

- FREE to FILL: the first byte of a packet is accepted.
- FREE to LOADED: a one-byte packet arrives, with its byte and the end strobe in the same cycle.
- FILL to LOADED: the end strobe arrives. The packet length is latched as the bank's count.
- LOADED to FREE: a CPU read consumes the last unread byte. The CPU selection then moves to the other bank.

An end strobe seen in FREE with no byte (a zero-length packet) keeps the bank in FREE.

A data read of one, two or four bytes pops that many bytes in one access. The first byte popped goes to the most significant used lane. Reading past the end of the packet returns zero in the missing lanes and sets a sticky underflow flag.

Top module: `bulk_rx_pingpong`

## Requirements
- R1: After reset, pkt_avail, buf_full and underflow are 0, and a count read returns 0.
- R2: Engine bytes (sie_valid with sie_data) are stored in arrival order into the bank the engine currently targets. On sie_end the number of bytes stored becomes that bank's count, and the engine moves on to the other bank. A zero-length packet leaves the bank FREE. Bytes beyond DEPTH in one packet are dropped, so the count saturates at DEPTH.
- R3: A count read (bus_sel=1, bus_we=0) returns the unread byte count of the CPU-selected bank in bus_rdata[6:0]. bus_rdata[31:7] are 0. A bank that is not LOADED reads as 0.
- R4: A byte data read (bus_sel=0, bus_size=0) returns the next unread byte in bus_rdata[7:0], with all other bits 0. It lowers the count by exactly one.
- R5: bus_size=1 (word) pops two bytes into bus_rdata[15:8] (first byte) and [7:0] (second byte). bus_size=2 or 3 (longword) pops four bytes into [31:24], [23:16], [15:8] and [7:0] in that order. The count falls by the number of bytes popped.
- R6: When a read brings the count to 0, the bank becomes FREE and the CPU selection moves to the other bank. The next count read then shows that bank's packet, or 0 if it holds none.
- R7: A data read that asks for more bytes than remain pops only the remaining bytes and returns 0 in the missing lanes. It leaves the count at 0 and sets underflow, which stays 1 until reset.
- R8: Bus writes (bus_en=1, bus_we=1) change neither count nor data, and bus_rdata is 0 whenever no read is in progress.
- R9: pkt_avail is 1 while at least one bank is LOADED. buf_full is 1 while both banks are LOADED. Engine bytes and end strobes that arrive while buf_full is 1 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sie_valid | input | 1 | Engine byte strobe |
| sie_data | input | 8 | Engine byte |
| sie_end | input | 1 | End of packet strobe (may accompany the last byte) |
| bus_en | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | Access is a write (ignored) |
| bus_sel | input | 1 | 0 = data window, 1 = count register |
| bus_size | input | 2 | 0 byte, 1 word, 2 or 3 longword |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| pkt_avail | output | 1 | At least one unread packet is held |
| buf_full | output | 1 | Both banks hold packets; the engine should NAK |
| underflow | output | 1 | Sticky over-read flag |

## Verification
The bench builds the block with DEPTH=8 rather than 64. With that value, an 11-byte packet is enough to show truncation at the bank limit, and both banks fill after a handful of bytes. This keeps the full-buffer drop, the bank switch and engine writes that overlap CPU reads within a short run. A behavioural queue model predicts the flags and the read data on every cycle.

// File: rtl/bulk_rx_pkg.sv
package bulk_rx_pkg;

    typedef enum logic [1:0] {
        BK_FREE   = 2'd0,
        BK_FILL   = 2'd1,
        BK_LOADED = 2'd2
    } bank_state_e;

    localparam int LANES = 4;

    // Bytes requested by one access: 0 -> 1, 1 -> 2, 2/3 -> 4
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/rx_bank.sv
module rx_bank
    import bulk_rx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_byte,
    input  logic [7:0]       wr_data,
    input  logic             wr_end,
    input  logic [2:0]       pop,
    output bank_state_e      state,
    output logic [CNT_W-1:0] remaining,
    output logic [31:0]      peek,
    output logic             closing,
    output logic             releasing
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]       mem [DEPTH];
    logic [CNT_W-1:0] fill_cnt;
    logic [CNT_W-1:0] pkt_len;
    logic [CNT_W-1:0] fill_next;
    logic [CNT_W-1:0] rd_idx;
    logic             take_byte;
    bank_state_e      state_d;

    always_comb begin
        take_byte = wr_byte && (state != BK_LOADED) && (fill_cnt < CNT_W'(DEPTH));
        fill_next = fill_cnt + (take_byte ? CNT_W'(1) : CNT_W'(0));
        closing   = wr_end && (state != BK_LOADED) && (fill_next != '0);
        releasing = (state == BK_LOADED) && (pop != 3'd0) && (CNT_W'(pop) >= remaining);
    end

    always_comb begin
        state_d = state;
        unique case (state)
            BK_FREE: begin
                if (closing)        state_d = BK_LOADED;
                else if (take_byte) state_d = BK_FILL;
            end
            BK_FILL: begin
                if (closing)        state_d = BK_LOADED;
            end
            BK_LOADED: begin
                if (releasing)      state_d = BK_FREE;
            end
            default:                state_d = BK_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= BK_FREE;
        else        state <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt  <= '0;
            pkt_len   <= '0;
            remaining <= '0;
        end else begin
            if (closing) begin
                pkt_len   <= fill_next;
                remaining <= fill_next;
                fill_cnt  <= '0;
            end else if (take_byte) begin
                fill_cnt  <= fill_next;
            end
            if (state == BK_LOADED && pop != 3'd0)
                remaining <= releasing ? '0 : remaining - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (take_byte) mem[fill_cnt[IDX_W-1:0]] <= wr_data;
    end

    assign rd_idx = pkt_len - remaining;

    always_comb begin
        logic [CNT_W:0] idx;
        peek = '0;
        for (int k = 0; k < LANES; k++) begin
            idx = {1'b0, rd_idx} + (CNT_W+1)'(k);
            if (idx < (CNT_W+1)'(DEPTH))
                peek[31-8*k -: 8] = mem[idx[IDX_W-1:0]];
        end
    end

endmodule

// File: rtl/rx_window.sv
module rx_window
    import bulk_rx_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             rd_req,
    input  logic [1:0]       size,
    input  logic [CNT_W-1:0] avail,
    input  logic [31:0]      peek,
    output logic [2:0]       pop,
    output logic [31:0]      data,
    output logic             short_read
);
    logic [2:0] req;

    always_comb begin
        req        = size_bytes(size);
        short_read = rd_req && (CNT_W'(req) > avail);
        if (!rd_req)         pop = 3'd0;
        else if (short_read) pop = avail[2:0];
        else                 pop = req;
        data = '0;
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(pop))
                data[(int'(req) - 1 - k)*8 +: 8] = peek[31-8*k -: 8];
        end
    end

endmodule

// File: rtl/bulk_rx_pingpong.sv
module bulk_rx_pingpong
    import bulk_rx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sie_valid,
    input  logic [7:0]  sie_data,
    input  logic        sie_end,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic        bus_sel,
    input  logic [1:0]  bus_size,
    output logic [31:0] bus_rdata,
    output logic        pkt_avail,
    output logic        buf_full,
    output logic        underflow
);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int NBANKS = 2;

    logic             fill_ptr;
    logic             read_ptr;
    bank_state_e      bk_state   [NBANKS];
    logic [CNT_W-1:0] bk_rem     [NBANKS];
    logic [31:0]      bk_peek    [NBANKS];
    logic             bk_close   [NBANKS];
    logic             bk_rel     [NBANKS];
    logic [2:0]       bk_pop     [NBANKS];
    logic [CNT_W-1:0] act_cnt;
    logic             data_rd;
    logic             cnt_rd;
    logic [2:0]       win_pop;
    logic [31:0]      win_data;
    logic             win_short;

    assign data_rd = bus_en && !bus_we && !bus_sel;
    assign cnt_rd  = bus_en && !bus_we &&  bus_sel;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        assign bk_pop[b] = (read_ptr == 1'(b)) ? win_pop : 3'd0;
        rx_bank #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_byte   (sie_valid && (fill_ptr == 1'(b))),
            .wr_data   (sie_data),
            .wr_end    (sie_end && (fill_ptr == 1'(b))),
            .pop       (bk_pop[b]),
            .state     (bk_state[b]),
            .remaining (bk_rem[b]),
            .peek      (bk_peek[b]),
            .closing   (bk_close[b]),
            .releasing (bk_rel[b])
        );
    end

    always_comb begin
        act_cnt = (bk_state[read_ptr] == BK_LOADED) ? bk_rem[read_ptr] : '0;
    end

    rx_window #(.CNT_W(CNT_W)) u_window (
        .rd_req     (data_rd),
        .size       (bus_size),
        .avail      (act_cnt),
        .peek       (bk_peek[read_ptr]),
        .pop        (win_pop),
        .data       (win_data),
        .short_read (win_short)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_ptr  <= 1'b0;
            read_ptr  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (bk_close[fill_ptr]) fill_ptr <= ~fill_ptr;
            if (bk_rel[read_ptr])   read_ptr <= ~read_ptr;
            if (win_short)          underflow <= 1'b1;
        end
    end

    always_comb begin
        pkt_avail = (bk_state[0] == BK_LOADED) || (bk_state[1] == BK_LOADED);
        buf_full  = (bk_state[0] == BK_LOADED) && (bk_state[1] == BK_LOADED);
        if (data_rd)     bus_rdata = win_data;
        else if (cnt_rd) bus_rdata = 32'(act_cnt);
        else             bus_rdata = '0;
    end

endmodule

// File: rtl/bulk_rx_checker.sv
module bulk_rx_checker #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_we,
    input logic             bus_sel,
    input logic [31:0]      bus_rdata,
    input logic             pkt_avail,
    input logic             buf_full,
    input logic             underflow,
    input logic [CNT_W-1:0] act_cnt,
    input logic             read_ptr,
    input logic [2:0]       win_pop
);
    logic dread;
    assign dread = bus_en && !bus_we && !bus_sel;

    AST_FULL_HAS_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> pkt_avail); // R9

    AST_COUNT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_sel) |-> (bus_rdata[31:7] == 25'd0)); // R3

    AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (dread && win_pop != 3'd0 && CNT_W'(win_pop) < act_cnt)
        |=> (act_cnt == $past(act_cnt) - CNT_W'($past(win_pop)))); // R4

    AST_DRAIN_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (win_pop != 3'd0 && CNT_W'(win_pop) == act_cnt)
        |=> (read_ptr != $past(read_ptr))); // R6

    AST_UNDERFLOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow); // R7

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dread && act_cnt == '0) |-> (bus_rdata == 32'd0)); // R7

    AST_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && act_cnt != '0) |=> (act_cnt == $past(act_cnt))); // R8

endmodule

bind bulk_rx_pingpong bulk_rx_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_rdata (bus_rdata),
    .pkt_avail (pkt_avail),
    .buf_full  (buf_full),
    .underflow (underflow),
    .act_cnt   (act_cnt),
    .read_ptr  (read_ptr),
    .win_pop   (win_pop)
);

// File: tb/tb_bulk_rx_pingpong.sv
module tb_bulk_rx_pingpong;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sie_valid = 1'b0;
    logic [7:0]  sie_data = 8'd0;
    logic        sie_end = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_sel = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [31:0] bus_rdata;
    logic        pkt_avail, buf_full, underflow;

    always #10 clk = ~clk;

    bulk_rx_pingpong #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .sie_valid(sie_valid), .sie_data(sie_data),
        .sie_end(sie_end), .bus_en(bus_en), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_size(bus_size), .bus_rdata(bus_rdata), .pkt_avail(pkt_avail),
        .buf_full(buf_full), .underflow(underflow)
    );

    int          total = 0;
    int          bad = 0;
    bit          done = 0;
    logic [7:0]  fill_q[$];
    logic [7:0]  data_q[$];
    int          len_q[$];
    bit          uf_m = 0;
    logic [31:0] last_rdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge with inputs set; returns at the next falling edge.
    task automatic step();
        int avail, n, take, loaded;
        logic [31:0] e;
        string tag;
        #5;
        chk("R9 pkt_avail", {31'd0, pkt_avail}, {31'd0, len_q.size() > 0});
        chk("R9 buf_full", {31'd0, buf_full}, {31'd0, len_q.size() == 2});
        chk("R7 underflow", {31'd0, underflow}, {31'd0, uf_m});
        avail = (len_q.size() > 0) ? len_q[0] : 0;
        e = '0; n = 0; take = 0;
        tag = "R8 no-read rdata";
        if (bus_en && !bus_we) begin
            if (bus_sel) begin
                e = avail;
                tag = "R3 count read";
            end else begin
                n = (bus_size == 2'd0) ? 1 : (bus_size == 2'd1) ? 2 : 4;
                take = (n < avail) ? n : avail;
                for (int k = 0; k < take; k++) e[(n-1-k)*8 +: 8] = data_q[k];
                tag = (n > avail) ? "R7 short read" : ((n == 1) ? "R4 byte read" : "R5 multi read");
            end
        end
        chk(tag, bus_rdata, e);
        last_rdata = bus_rdata;
        loaded = len_q.size();
        if (take > 0) begin
            for (int k = 0; k < take; k++) void'(data_q.pop_front());
            len_q[0] = len_q[0] - take;
            if (len_q[0] == 0) void'(len_q.pop_front());
        end
        if (n > avail) uf_m = 1;
        if (loaded < 2) begin
            if (sie_valid && fill_q.size() < DEPTH) fill_q.push_back(sie_data);
            if (sie_end && fill_q.size() > 0) begin
                len_q.push_back(fill_q.size());
                foreach (fill_q[i]) data_q.push_back(fill_q[i]);
                fill_q.delete();
            end
        end
        @(negedge clk);
    endtask

    task automatic clear_in();
        sie_valid = 0; sie_end = 0; bus_en = 0; bus_we = 0; bus_sel = 0; bus_size = 0;
    endtask

    task automatic send_pkt(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            sie_valid = 1; sie_data = base + 8'(i); sie_end = (i == n - 1);
            step();
            clear_in();
        end
    endtask

    task automatic rd(input logic sel, input logic [1:0] sz);
        bus_en = 1; bus_we = 0; bus_sel = sel; bus_size = sz;
        step();
        clear_in();
    endtask

    task automatic wr(input logic sel, input logic [1:0] sz);
        bus_en = 1; bus_we = 1; bus_sel = sel; bus_size = sz;
        step();
        clear_in();
    endtask

    task automatic cnt_is(input string tag, input int exp);
        rd(1'b1, 2'd0);
        chk(tag, last_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 pkt_avail", {31'd0, pkt_avail}, 32'd0);
        chk("R1 buf_full", {31'd0, buf_full}, 32'd0);
        chk("R1 underflow", {31'd0, underflow}, 32'd0);
        cnt_is("R1 count", 0);

        // R2 packet capture, R4 byte pop, R5 word, R7 short longword
        send_pkt(5, 8'h10);
        cnt_is("R2 length latched", 5);
        rd(1'b0, 2'd0);
        chk("R4 first byte", last_rdata, 32'h0000_0010);
        cnt_is("R4 count minus one", 4);
        rd(1'b0, 2'd1);
        chk("R5 word lanes", last_rdata, 32'h0000_1112);
        cnt_is("R5 count minus two", 2);
        rd(1'b0, 2'd2);
        chk("R7 short read lanes", last_rdata, 32'h1314_0000);
        chk("R7 sticky flag", {31'd0, underflow}, 32'd1);
        cnt_is("R6 drained bank reads zero", 0);

        // R9 both banks, drop while full; R8 writes ignored; R6 switch
        send_pkt(8, 8'h20);
        send_pkt(3, 8'h40);
        chk("R9 full", {31'd0, buf_full}, 32'd1);
        send_pkt(2, 8'h60);
        wr(1'b0, 2'd2);
        wr(1'b1, 2'd0);
        cnt_is("R8 count unchanged", 8);
        rd(1'b0, 2'd2);
        chk("R5 long lanes", last_rdata, 32'h2021_2223);
        rd(1'b0, 2'd3);
        chk("R5 size3 long", last_rdata, 32'h2425_2627);
        cnt_is("R6 second bank count", 3);
        rd(1'b0, 2'd0);
        chk("R6 second bank data", last_rdata, 32'h0000_0040);
        rd(1'b0, 2'd1);
        chk("R5 word end", last_rdata, 32'h0000_4142);
        chk("R9 dropped packet", {31'd0, pkt_avail}, 32'd0);

        // R2 truncation at DEPTH, engine writes overlapping CPU reads
        send_pkt(11, 8'h80);
        cnt_is("R2 saturated count", DEPTH);
        for (int i = 0; i < 3; i++) begin
            sie_valid = 1; sie_data = 8'hA0 + 8'(i); sie_end = (i == 2);
            bus_en = 1; bus_sel = 0; bus_size = 2'd0;
            step();
            clear_in();
        end
        cnt_is("R4 overlap count", DEPTH - 3);
        rd(1'b0, 2'd2);
        rd(1'b0, 2'd0);
        cnt_is("R6 next packet", 3);
        rd(1'b0, 2'd2);
        chk("R7 partial long", last_rdata, 32'hA0A1_A200);

        // R2 zero-length packet discarded
        sie_end = 1;
        step();
        clear_in();
        step();
        chk("R2 zero-length", {31'd0, pkt_avail}, 32'd0);
        rd(1'b0, 2'd1);
        chk("R7 empty read", last_rdata, 32'd0);
        wr(1'b0, 2'd0);
        chk("R8 idle rdata", last_rdata, 32'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule